// File: doc/BRIEF.md
# Field-selected register ALU

This block is the register-arithmetic execution unit of a processor that works on 4-bit nibbles. It holds four 64-bit working registers and a 4-bit pointer register. Each command carries an operation code, a byte that names two registers, and a field code that picks a group of nibbles. The unit pulls that nibble group out of both named registers, right-aligns each, computes a result, and then places the result back into the same nibbles of the first named register. Nibbles outside the group are left alone.

Commands use a valid/ready handshake. When the command has finished, a one-cycle done pulse appears together with the number of extra nibbles the program counter must skip. Multiply, divide and remainder run over many cycles in an iterative unit. All other operations finish two cycles after acceptance. A simple load port and a combinational read port give access to the registers and the pointer.

Top module: `nib_field_alu`

## Requirements
- R1: After reset all four registers and the pointer read zero, `cmd_ready` is high, and `busy`, `done` and `div_zero` are low.
- R2: In `cmd_regs`, bits 1:0 select the destination, which is also the first operand, and bits 3:2 select the second operand. The encoding is 0=A, 1=B, 2=C, 3=D.
- R3: Field codes pick nibbles as follows. Code 0 is the nibble at the pointer. Code 1 is nibbles 0 up to the pointer. Code 2 is nibble 2. Code 3 is nibbles 0–2. Code 4 is nibble 15. Code 5 is nibbles 3–14. Code 6 is nibbles 0–1. Code 7 is all 16 nibbles. Code 15 is nibbles 0–4. Each extracted field is shifted down to bit 0.
- R4: Field codes 8 to 14 act as the whole word, for both reading and writing.
- R5: The result is cut to the field width and written only into the field's nibbles of the destination. Every other nibble of every register is unchanged.
- R6: Operation codes 0x80 to 0x8A are: copy second operand, add, subtract, multiply, divide, remainder, bitwise NOT of second operand, negate second operand, shift left by the second operand, shift right by the second operand, and XOR. All arithmetic is 64-bit modulo 2^64. A shift by 64 or more gives zero.
- R7: Multiply keeps the low 64 bits of the product. While a multiply, divide or remainder is running, `busy` stays high and `cmd_ready` stays low until `done`.
- R8: Divide by zero writes all ones, cut to the field width. Remainder by zero writes the dividend. In both cases `div_zero` is high during the `done` cycle.
- R9: Each accepted command gives exactly one one-cycle `done` pulse. With it, `pc_adv` is 2 for codes 0x80–0x8A. Any other code changes no register and gives `pc_adv` = 0.
- R10: A register or pointer load acts only while `cmd_ready` is high and is ignored while busy. A load in the same cycle that a command is accepted takes effect, but the command uses the values from before the load.
- R11: The field codes 0 and 1 use the pointer value at command acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command and loads accepted |
| cmd_op | input | 8 | Operation code |
| cmd_regs | input | 4 | Destination (1:0) and second operand (3:2) |
| cmd_field | input | 4 | Field code |
| ld_reg_en | input | 1 | Load a register |
| ld_reg_sel | input | 2 | Register to load |
| ld_reg_data | input | 64 | Load value |
| ld_p_en | input | 1 | Load pointer |
| ld_p_val | input | 4 | Pointer load value |
| rd_sel | input | 2 | Register to read |
| rd_data | output | 64 | Selected register contents |
| p_val | output | 4 | Pointer contents |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command complete pulse |
| pc_adv | output | 3 | Extra program-counter nibbles, valid with done |
| div_zero | output | 1 | Division by zero, valid with done |

## Verification
Two actions can land on the same clock edge: a register or pointer load and the acceptance of a command. The bench issues both together. It loads the destination register, the second-operand register, or the pointer, and then checks that the operands and field position come from the values before the load. It also checks that the result is written on top of the freshly loaded destination. A second case drives loads while a multi-cycle command is busy and confirms at the read port that they were dropped.

// File: rtl/fa_pkg.sv
// Shared codes for the field-selected register ALU.
// Assumes 8-bit operation codes and 4-bit field codes.
package fa_pkg;
    typedef enum logic [7:0] {
        OP_MOVE = 8'h80,
        OP_ADD  = 8'h81,
        OP_SUB  = 8'h82,
        OP_MUL  = 8'h83,
        OP_DIV  = 8'h84,
        OP_REM  = 8'h85,
        OP_INV  = 8'h86,
        OP_NEG  = 8'h87,
        OP_SHL  = 8'h88,
        OP_SHR  = 8'h89,
        OP_XOR  = 8'h8A
    } alu_op_e;

    localparam logic [3:0] FLD_AT_P   = 4'd0;
    localparam logic [3:0] FLD_UPTO_P = 4'd1;
    localparam logic [3:0] FLD_NIB2   = 4'd2;
    localparam logic [3:0] FLD_LOW3   = 4'd3;
    localparam logic [3:0] FLD_TOP    = 4'd4;
    localparam logic [3:0] FLD_MID    = 4'd5;
    localparam logic [3:0] FLD_LOW2   = 4'd6;
    localparam logic [3:0] FLD_WORD   = 4'd7;
    localparam logic [3:0] FLD_LOW5   = 4'd15;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_MDWAIT
    } ctl_state_e;
endpackage

// File: rtl/fa_field_map.sv
// Field decoder. It turns a field code and the pointer into a bit
// offset and a right-aligned width mask.
// Assumes a 4-bit nibble and a word of 16 nibbles. Unlisted codes,
// including the user-mask range, decode as the whole word.
module fa_field_map
    import fa_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic [3:0]                        field,
    input  logic [$clog2(WORD_W/4)-1:0]       ptr,
    output logic [$clog2(WORD_W)-1:0]         shamt,
    output logic [WORD_W-1:0]                 wmask
);
    localparam int NIBS = WORD_W / 4;
    localparam int CW   = $clog2(NIBS) + 1;
    localparam int SHW  = $clog2(WORD_W);

    logic [CW-1:0] lo_nib;
    logic [CW-1:0] cnt_nib;

    // Pick the lowest nibble and the nibble count for each field code.
    always_comb begin
        lo_nib  = '0;
        cnt_nib = CW'(NIBS);
        case (field)
            FLD_AT_P:   begin lo_nib = CW'(ptr); cnt_nib = CW'(1); end
            FLD_UPTO_P: begin cnt_nib = CW'(ptr) + CW'(1); end
            FLD_NIB2:   begin lo_nib = CW'(2); cnt_nib = CW'(1); end
            FLD_LOW3:   cnt_nib = CW'(3);
            FLD_TOP:    begin lo_nib = CW'(NIBS - 1); cnt_nib = CW'(1); end
            FLD_MID:    begin lo_nib = CW'(3); cnt_nib = CW'(NIBS - 4); end
            FLD_LOW2:   cnt_nib = CW'(2);
            FLD_LOW5:   cnt_nib = CW'(5);
            default:    cnt_nib = CW'(NIBS);
        endcase
    end

    // Convert the nibble bounds into a bit offset and a mask.
    always_comb begin
        shamt = SHW'({lo_nib, 2'b00});
        if (cnt_nib >= CW'(NIBS))
            wmask = '1;
        else
            wmask = (WORD_W'(1) << {cnt_nib, 2'b00}) - WORD_W'(1);
    end
endmodule

// File: rtl/fa_alu.sv
// Single-cycle operation decoder and datapath. It flags the codes that
// need the iterative unit, and it resolves divide and remainder by zero
// directly.
// Assumes the operands are already extracted and right-aligned.
module fa_alu
    import fa_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic [7:0]        op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] res,
    output logic              known,
    output logic              multi,
    output logic              dz
);
    // Compute the combinational result and the decode flags.
    always_comb begin
        res   = '0;
        known = 1'b1;
        multi = 1'b0;
        dz    = 1'b0;
        case (op)
            OP_MOVE: res = b;
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_MUL:  multi = 1'b1;
            OP_DIV: begin
                if (b == '0) begin res = '1; dz = 1'b1; end
                else multi = 1'b1;
            end
            OP_REM: begin
                if (b == '0) begin res = a; dz = 1'b1; end
                else multi = 1'b1;
            end
            OP_INV:  res = ~b;
            OP_NEG:  res = '0 - b;
            OP_SHL:  res = a << b;
            OP_SHR:  res = a >> b;
            OP_XOR:  res = a ^ b;
            default: known = 1'b0;
        endcase
    end
endmodule

// File: rtl/fa_muldiv.sv
// Iterative unit. It does shift-add multiply and restoring divide, one
// bit per cycle. After a start pulse it gives a one-cycle fin pulse WORD_W
// cycles later.
// Assumes the divisor is nonzero. Start is only given while idle.
module fa_muldiv #(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_div,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              fin,
    output logic [WORD_W-1:0] prod,
    output logic [WORD_W-1:0] quo,
    output logic [WORD_W-1:0] rem
);
    localparam int CNTW = $clog2(WORD_W) + 1;

    logic              run;
    logic              div_q;
    logic [CNTW-1:0]   cnt;
    logic [WORD_W-1:0] acc, mc, mp, part;
    logic [WORD_W-1:0] a_q, b_q;
    logic [WORD_W:0]   trial, diff;

    // Form the next partial remainder and the trial subtraction.
    always_comb begin
        trial = {part, mp[WORD_W-1]};
        diff  = trial - {1'b0, mc};
    end

    // Step the multiply or divide by one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; div_q <= 1'b0; cnt <= '0; fin <= 1'b0;
            acc <= '0; mc <= '0; mp <= '0; part <= '0; a_q <= '0; b_q <= '0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                run <= 1'b1; div_q <= is_div; cnt <= CNTW'(WORD_W);
                acc <= '0; part <= '0; mc <= is_div ? b : a; mp <= is_div ? a : b;
                a_q <= a; b_q <= b;
            end else if (run) begin
                if (div_q) begin
                    if (!diff[WORD_W]) begin
                        part <= diff[WORD_W-1:0];
                        mp   <= {mp[WORD_W-2:0], 1'b1};
                    end else begin
                        part <= trial[WORD_W-1:0];
                        mp   <= {mp[WORD_W-2:0], 1'b0};
                    end
                end else begin
                    if (mp[0]) acc <= acc + mc;
                    mc <= mc << 1;
                    mp <= mp >> 1;
                end
                cnt <= cnt - CNTW'(1);
                if (cnt == CNTW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign prod = acc;
    assign quo  = mp;
    assign rem  = part;

    assert_mul_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !div_q) |-> (prod == a_q * b_q));
    assert_div_identity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && div_q) |-> ((quo * b_q + rem == a_q) && (rem < b_q)));
    assert_run_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != '0));
endmodule

// File: rtl/nib_field_alu.sv
// Top of the field-selected register ALU. It holds the register file and
// the pointer. It latches the extracted operands at acceptance, runs the
// operation, and inserts the result into the destination field.
// Assumes 4-bit nibbles and a register-pair byte of two selects.
module nib_field_alu
    import fa_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int NREG   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  logic [7:0]                   cmd_op,
    input  logic [2*$clog2(NREG)-1:0]    cmd_regs,
    input  logic [3:0]                   cmd_field,
    input  logic                         ld_reg_en,
    input  logic [$clog2(NREG)-1:0]      ld_reg_sel,
    input  logic [WORD_W-1:0]            ld_reg_data,
    input  logic                         ld_p_en,
    input  logic [$clog2(WORD_W/4)-1:0]  ld_p_val,
    input  logic [$clog2(NREG)-1:0]      rd_sel,
    output logic [WORD_W-1:0]            rd_data,
    output logic [$clog2(WORD_W/4)-1:0]  p_val,
    output logic                         busy,
    output logic                         done,
    output logic [2:0]                   pc_adv,
    output logic                         div_zero
);
    localparam int RSW = $clog2(NREG);
    localparam int PW  = $clog2(WORD_W / 4);
    localparam int SHW = $clog2(WORD_W);

    ctl_state_e        state;
    logic [WORD_W-1:0] regs [NREG];
    logic [PW-1:0]     p_reg;
    logic [7:0]        op_q;
    logic [RSW-1:0]    dst_q;
    logic [SHW-1:0]    sh_q, sh_new;
    logic [WORD_W-1:0] wm_q, wm_new, a_q, b_q;
    logic [WORD_W-1:0] a_ext, b_ext, alu_res, md_prod, md_quo, md_rem;
    logic [WORD_W-1:0] res, place, dst_cur, dst_next;
    logic              alu_known, alu_multi, alu_dz, md_fin, md_start;
    logic              accept, ld_fire, p_fire, wr_fire, fin_ev;

    assign cmd_ready = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign ld_fire   = ld_reg_en && cmd_ready;
    assign p_fire    = ld_p_en && cmd_ready;
    assign rd_data   = regs[rd_sel];
    assign p_val     = p_reg;

    fa_field_map #(.WORD_W(WORD_W)) u_map (
        .field(cmd_field), .ptr(p_reg), .shamt(sh_new), .wmask(wm_new)
    );

    // Extract both operand fields from the registers before any load.
    always_comb begin
        a_ext = (regs[cmd_regs[RSW-1:0]] >> sh_new) & wm_new;
        b_ext = (regs[cmd_regs[2*RSW-1:RSW]] >> sh_new) & wm_new;
    end

    fa_alu #(.WORD_W(WORD_W)) u_alu (
        .op(op_q), .a(a_q), .b(b_q), .res(alu_res),
        .known(alu_known), .multi(alu_multi), .dz(alu_dz)
    );

    assign md_start = (state == ST_EXEC) && alu_multi;

    fa_muldiv #(.WORD_W(WORD_W)) u_md (
        .clk(clk), .rst_n(rst_n), .start(md_start), .is_div(op_q != OP_MUL),
        .a(a_q), .b(b_q), .fin(md_fin), .prod(md_prod), .quo(md_quo), .rem(md_rem)
    );

    // Choose the result source and build the merged destination word.
    always_comb begin
        if (state == ST_MDWAIT)
            res = (op_q == OP_MUL) ? md_prod : ((op_q == OP_DIV) ? md_quo : md_rem);
        else
            res = alu_res;
        place    = wm_q << sh_q;
        dst_cur  = regs[dst_q];
        dst_next = (dst_cur & ~place) | ((res & wm_q) << sh_q);
        fin_ev   = ((state == ST_EXEC) && !alu_multi) || ((state == ST_MDWAIT) && md_fin);
        wr_fire  = fin_ev && alu_known;
    end

    // Sequence the command through execute and the iterative wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; op_q <= '0; dst_q <= '0; sh_q <= '0;
            wm_q <= '0; a_q <= '0; b_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state <= ST_EXEC; op_q <= cmd_op; dst_q <= cmd_regs[RSW-1:0];
                    sh_q <= sh_new; wm_q <= wm_new; a_q <= a_ext; b_q <= b_ext;
                end
                ST_EXEC:   state <= alu_multi ? ST_MDWAIT : ST_IDLE;
                ST_MDWAIT: if (md_fin) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Register the completion pulse and its side outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0; pc_adv <= '0; div_zero <= 1'b0;
        end else begin
            done     <= fin_ev;
            pc_adv   <= (fin_ev && alu_known) ? 3'd2 : 3'd0;
            div_zero <= fin_ev && (state == ST_EXEC) && alu_dz;
        end
    end

    // Hold the pointer; loads only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) p_reg <= '0;
        else if (p_fire) p_reg <= ld_p_val;
    end

    // One storage word per register: load port first, result write otherwise.
    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else if (ld_fire && (ld_reg_sel == RSW'(gi))) word_q <= ld_reg_data;
            else if (wr_fire && (dst_q == RSW'(gi))) word_q <= dst_next;
        end
        assign regs[gi] = word_q;
    end

    assert_outside_field_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (((dst_cur ^ $past(dst_cur)) & ~$past(place)) == '0));
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_pc_adv_values_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((pc_adv == 3'd2) || (pc_adv == 3'd0)));
    assert_dz_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> done);
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MDWAIT && !md_fin) |=> busy);
endmodule

// File: tb/sim_nib_field_alu.sv
module sim_nib_field_alu;
    localparam time CYC = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_op = '0;
    logic [3:0]  cmd_regs = '0;
    logic [3:0]  cmd_field = '0;
    logic        ld_reg_en = 1'b0;
    logic [1:0]  ld_reg_sel = '0;
    logic [63:0] ld_reg_data = '0;
    logic        ld_p_en = 1'b0;
    logic [3:0]  ld_p_val = '0;
    logic [1:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic [3:0]  p_val;
    logic        busy, done, div_zero;
    logic [2:0]  pc_adv;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] mreg [4];
    logic [3:0]  mp = '0;

    always #(CYC/2) clk = ~clk;

    nib_field_alu u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_regs(cmd_regs), .cmd_field(cmd_field),
        .ld_reg_en(ld_reg_en), .ld_reg_sel(ld_reg_sel), .ld_reg_data(ld_reg_data),
        .ld_p_en(ld_p_en), .ld_p_val(ld_p_val), .rd_sel(rd_sel), .rd_data(rd_data),
        .p_val(p_val), .busy(busy), .done(done), .pc_adv(pc_adv), .div_zero(div_zero)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Field layout from the requirement table (R3, R4, R11).
    function automatic void fmap(input logic [3:0] f, input logic [3:0] p, output int lo, output int n);
        lo = 0; n = 16;
        case (f)
            4'd0: begin lo = int'(p); n = 1; end
            4'd1: n = int'(p) + 1;
            4'd2: begin lo = 2; n = 1; end
            4'd3: n = 3;
            4'd4: begin lo = 15; n = 1; end
            4'd5: begin lo = 3; n = 12; end
            4'd6: n = 2;
            4'd15: n = 5;
            default: n = 16;
        endcase
    endfunction

    function automatic logic [63:0] nmask(input int n);
        return (n >= 16) ? '1 : ((64'd1 << (4 * n)) - 64'd1);
    endfunction

    function automatic void model_op(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b,
                                     output logic [63:0] r, output bit known, output bit dz);
        known = 1; dz = 0; r = '0;
        case (op)
            8'h80: r = b;
            8'h81: r = a + b;
            8'h82: r = a - b;
            8'h83: r = a * b;
            8'h84: if (b == 0) begin r = '1; dz = 1; end else r = a / b;
            8'h85: if (b == 0) begin r = a; dz = 1; end else r = a % b;
            8'h86: r = ~b;
            8'h87: r = 64'd0 - b;
            8'h88: r = (b >= 64) ? 64'd0 : (a << b[5:0]);
            8'h89: r = (b >= 64) ? 64'd0 : (a >> b[5:0]);
            8'h8A: r = a ^ b;
            default: known = 0;
        endcase
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i);
            #1;
            chk(rd_data === mreg[i], req, rd_data, mreg[i]);
        end
    endtask

    task automatic load_reg(input int sel, input logic [63:0] v);
        @(negedge clk);
        ld_reg_en = 1; ld_reg_sel = 2'(sel); ld_reg_data = v;
        @(negedge clk);
        ld_reg_en = 0;
        mreg[sel] = v;
    endtask

    task automatic load_p(input logic [3:0] v);
        @(negedge clk);
        ld_p_en = 1; ld_p_val = v;
        @(negedge clk);
        ld_p_en = 0;
        mp = v;
    endtask

    // Run one command. Optionally load a register (or the pointer) in the
    // accept cycle, or try a load during the busy phase.
    task automatic run_cmd(input logic [7:0] op, input logic [3:0] rg, input logic [3:0] fld,
                           input string req, input bit same_ld, input int ld_sel,
                           input logic [63:0] ld_v, input bit same_p, input logic [3:0] pv,
                           input bit busy_ld);
        int lo, n, wait_n;
        logic [63:0] a, b, r, m;
        bit known, dz;
        @(negedge clk);
        fmap(fld, mp, lo, n);
        m = nmask(n);
        a = (mreg[rg[1:0]] >> (4 * lo)) & m;
        b = (mreg[rg[3:2]] >> (4 * lo)) & m;
        model_op(op, a, b, r, known, dz);
        cmd_valid = 1; cmd_op = op; cmd_regs = rg; cmd_field = fld;
        ld_reg_en = same_ld; ld_reg_sel = 2'(ld_sel); ld_reg_data = ld_v;
        ld_p_en = same_p; ld_p_val = pv;
        @(negedge clk);
        cmd_valid = 0; ld_reg_en = 0; ld_p_en = 0;
        if (same_ld) mreg[ld_sel] = ld_v;
        if (same_p) mp = pv;
        if (busy_ld) begin
            chk(busy === 1'b1 && cmd_ready === 1'b0, "R7 busy", {62'd0, busy, cmd_ready}, 64'd2);
            ld_reg_en = 1; ld_reg_sel = 2'(ld_sel); ld_reg_data = ~ld_v;
            ld_p_en = 1; ld_p_val = ~mp;
            @(negedge clk);
            ld_reg_en = 0; ld_p_en = 0;
        end
        wait_n = 0;
        while (!done && wait_n < 200) begin
            @(negedge clk);
            wait_n++;
        end
        chk(done === 1'b1, "R9 done", {63'd0, done}, 64'd1);
        chk(pc_adv === (known ? 3'd2 : 3'd0), "R9 pc_adv", {61'd0, pc_adv}, known ? 64'd2 : 64'd0);
        chk(div_zero === dz, "R8 div_zero", {63'd0, div_zero}, {63'd0, dz});
        if (known)
            mreg[rg[1:0]] = (mreg[rg[1:0]] & ~(m << (4 * lo))) | ((r & m) << (4 * lo));
        check_regs(req);
        chk(p_val === mp, "R10 pointer", {60'd0, p_val}, {60'd0, mp});
        @(negedge clk);
        chk(done === 1'b0, "R9 single pulse", {63'd0, done}, 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CYC * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        for (int i = 0; i < 4; i++) mreg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_regs("R1 reset regs");
        chk(p_val === 4'd0 && cmd_ready === 1'b1 && busy === 1'b0 && done === 1'b0 && div_zero === 1'b0,
            "R1 reset outputs", {59'd0, p_val, cmd_ready}, 64'd1);

        load_reg(0, 64'h0123_4567_89AB_CDEF);
        load_reg(1, 64'hFEDC_BA98_7654_3210);
        load_reg(2, 64'h0000_0000_0000_0003);
        load_reg(3, 64'h1111_2222_3333_4444);

        // R2 pair decode: D gets C (copy), whole word
        run_cmd(8'h80, 4'b1011, 4'd7, "R2 copy C to D", 0, 0, 0, 0, 0, 0);
        // R3 middle nibbles add, A += B
        run_cmd(8'h81, 4'b0100, 4'd5, "R3 mid add", 0, 0, 0, 0, 0, 0);
        // R11 pointer nibble and up-to-pointer at P=5, 0, 15
        load_p(4'd5);
        run_cmd(8'h81, 4'b0001, 4'd0, "R11 nibble at P", 0, 0, 0, 0, 0, 0);
        run_cmd(8'h82, 4'b0001, 4'd1, "R11 up to P", 0, 0, 0, 0, 0, 0);
        load_p(4'd15);
        run_cmd(8'h8A, 4'b0110, 4'd1, "R11 up to P=15", 0, 0, 0, 0, 0, 0);
        load_p(4'd0);
        run_cmd(8'h87, 4'b1000, 4'd1, "R11 up to P=0", 0, 0, 0, 0, 0, 0);
        // R4 user-mask code acts as whole word
        run_cmd(8'h86, 4'b0100, 4'd9, "R4 code 9 whole", 0, 0, 0, 0, 0, 0);
        run_cmd(8'h81, 4'b1101, 4'd14, "R4 code 14 whole", 0, 0, 0, 0, 0, 0);
        // R5 truncation: top nibble add overflow
        load_reg(0, 64'hF000_0000_0000_0000);
        load_reg(1, 64'h3000_0000_0000_0001);
        run_cmd(8'h81, 4'b0100, 4'd4, "R5 truncate top", 0, 0, 0, 0, 0, 0);
        // R6 shifts
        load_reg(2, 64'd4);
        run_cmd(8'h88, 4'b1001, 4'd7, "R6 shl by 4", 0, 0, 0, 0, 0, 0);
        run_cmd(8'h89, 4'b1000, 4'd7, "R6 shr by 4", 0, 0, 0, 0, 0, 0);
        // R7 multiply full width
        load_reg(0, 64'hFFFF_FFFF_FFFF_FFF1);
        load_reg(1, 64'h1234_5678_9ABC_DEF1);
        run_cmd(8'h83, 4'b0100, 4'd7, "R7 mul low bits", 0, 0, 0, 0, 0, 0);
        run_cmd(8'h84, 4'b0100, 4'd15, "R6 divide", 0, 0, 0, 0, 0, 0);
        // R8 divide and remainder by zero
        load_reg(3, 64'd0);
        run_cmd(8'h84, 4'b1100, 4'd3, "R8 div by zero", 0, 0, 0, 0, 0, 0);
        load_reg(2, 64'h0000_0000_0000_0ABC);
        run_cmd(8'h85, 4'b1110, 4'd3, "R8 rem by zero", 0, 0, 0, 0, 0, 0);
        // R9 unknown codes leave registers alone
        run_cmd(8'h8B, 4'b0100, 4'd7, "R9 unknown 8B", 0, 0, 0, 0, 0, 0);
        run_cmd(8'h7F, 4'b0001, 4'd7, "R9 unknown 7F", 0, 0, 0, 0, 0, 0);
        // R10 same-cycle load of destination, of source, and of pointer
        run_cmd(8'h81, 4'b0100, 4'd6, "R10 same-cycle dst load", 1, 0, 64'hAAAA_5555_AAAA_5555, 0, 0, 0);
        run_cmd(8'h82, 4'b0100, 4'd7, "R10 same-cycle src load", 1, 1, 64'h0000_0000_0000_0777, 0, 0, 0);
        load_p(4'd7);
        run_cmd(8'h80, 4'b0100, 4'd0, "R10 same-cycle P load", 0, 0, 0, 1, 4'd2, 0);
        // R10 loads dropped while busy (multi-cycle and single-cycle)
        run_cmd(8'h83, 4'b0100, 4'd15, "R10 busy load dropped mul", 0, 3, 64'h1234, 0, 0, 1);
        run_cmd(8'h81, 4'b0110, 4'd7, "R10 busy load dropped add", 0, 2, 64'h9999, 0, 0, 1);

        // Random mix
        for (int k = 0; k < 160; k++) begin
            logic [7:0] op;
            logic [3:0] fld;
            if (k % 10 == 0) begin
                for (int j = 0; j < 4; j++) begin
                    logic [63:0] v;
                    v = {$urandom, $urandom};
                    if ($urandom % 3 == 0) v = v & 64'hFF;
                    load_reg(j, v);
                end
                load_p(4'($urandom));
            end
            op = ($urandom % 12 == 0) ? 8'h8B : (8'h80 + 8'($urandom % 11));
            fld = 4'($urandom);
            run_cmd(op, 4'($urandom), fld, "R6 random", 0, 0, 0, 0, 0, 0);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule